// File: doc/BRIEF.md
# Legacy Graphics Request Router

The router sits on the processor's outbound request path. It decides, for each memory or I/O request, whether the request belongs to the graphics expansion port or to the default downstream port. The decision uses four inputs. The first is a legacy-graphics enable. The second is a mono-display enable. The third is an ISA-compatibility enable, which trims the I/O window. The fourth is a pair of base/limit windows, one for I/O space and one for memory space.

The address decode is combinational. The chosen destination is captured in a register stage. One clock after a valid request, exactly one of two destination lines is high for one cycle. A cycle without a request leaves every output low on the following cycle. A configuration that turns on mono-display without legacy graphics is not supported. Such a request raises a flag alongside its destination.

Top module: `legacy_gfx_router`

## Requirements
- R1: After reset, and in the cycle after any cycle with `reqValid` low, `dstExp`, `dstDef` and `undefCfg` are all 0.
- R2: In the cycle after a cycle with `reqValid` high, exactly one of `dstExp`/`dstDef` is 1. The decision reflects the request and configuration sampled at that earlier edge.
- R3: With `vgaEn`=1, a memory request to 0xA0000..0xBFFFF goes to `dstExp`. The memory window registers do not affect this, but the mono carve-out of R6 still applies.
- R4: With `vgaEn`=1, an I/O request goes to `dstExp` when address bits [9:0] lie in 0x3B0..0x3BB or 0x3C0..0x3DF. Address bits [15:10], `ioBase`, `ioLimit` and `isaEn` do not affect this. R5 and R6 are the exceptions.
- R5: With `vgaEn`=1, an I/O request whose bits [9:0] lie in 0x3BC..0x3BF always goes to `dstDef`.
- R6: With `vgaEn`=1 and `mdaEn`=1, two kinds of request go to `dstDef`, taking priority over R3 and R4. The first is an I/O request whose bits [9:0] are 0x3B4, 0x3B5, 0x3B8..0x3BA or 0x3BF. The second is a memory request to 0xB0000..0xB7FFF.
- R7: An I/O request not claimed by R4–R6 goes to `dstExp` only when two conditions hold. First, `ioBase` <= address[15:12] <= `ioLimit` (both bounds inclusive). Second, `isaEn`=0 or address bits [9:8] are 00. Otherwise it goes to `dstDef`. I/O address bits above 15 are ignored.
- R8: A memory request not claimed by R3/R6 goes to `dstExp` only when `memBase` <= address[31:20] <= `memLimit`. Otherwise it goes to `dstDef`.
- R9: `undefCfg` is 1 in the cycle after a valid request sampled with `vgaEn`=0 and `mdaEn`=1. That request is routed as if both enables were 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqIsIo | input | 1 | 1 = I/O request, 0 = memory request |
| reqAddr | input | 32 | Request address |
| vgaEn | input | 1 | Legacy graphics ranges claimed by the expansion port |
| mdaEn | input | 1 | Mono-display ranges carved back to the default port |
| isaEn | input | 1 | Excludes I/O addresses with bits [9:8] nonzero from the I/O window |
| ioBase | input | 4 | I/O window base, 4 KB units (address bits [15:12]) |
| ioLimit | input | 4 | I/O window limit, inclusive |
| memBase | input | 12 | Memory window base, 1 MB units (address bits [31:20]) |
| memLimit | input | 12 | Memory window limit, inclusive |
| dstExp | output | 1 | Registered: request routed to the expansion port |
| dstDef | output | 1 | Registered: request routed to the default port |
| undefCfg | output | 1 | Registered: request seen under the unsupported enable combination |

## Verification
The block holds only the output register, so any faulty decode appears at the ports on the cycle right after the offending request. There it shows up as a swapped destination line, two lines high or none high, and nothing can stay hidden longer than one cycle. Faults on range edges are the hardest to catch (0x3BB against 0x3BC, 0xB7FFF against 0xB8000, inclusive limits), so directed cases sit exactly on those edges. Random traffic biased into the legacy windows then covers the interaction of all four enables.

// File: rtl/lgr_pkg.sv
`timescale 1ns/1ps
package lgr_pkg;
  // Range hits produced by the datapath for the control logic
  typedef struct packed {
    logic vgaIo;     // legacy graphics I/O ports (low 10 bits)
    logic monoIo;    // mono-display I/O subset
    logic portWin;   // 0x3BC..0x3BF window
    logic ioWin;     // inside I/O base/limit
    logic ioHighNz;  // I/O address bits [9:8] nonzero
    logic vgaMem;    // 0xA0000..0xBFFFF
    logic monoMem;   // 0xB0000..0xB7FFF
    logic memWin;    // inside memory base/limit
  } hitFlags_t;

  // Strobes from control to the output register
  typedef struct packed {
    logic load;
    logic toExp;
    logic undef;
  } ctrlStrobe_t;
endpackage

// File: rtl/lgr_datapath.sv
`timescale 1ns/1ps
module lgr_datapath
  import lgr_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int IO_W     = 16,
  parameter int IO_GRAN  = 12,
  parameter int MEM_GRAN = 20
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          reqAddr,
  input  logic [IO_W-IO_GRAN-1:0]    ioBase,
  input  logic [IO_W-IO_GRAN-1:0]    ioLimit,
  input  logic [ADDR_W-MEM_GRAN-1:0] memBase,
  input  logic [ADDR_W-MEM_GRAN-1:0] memLimit,
  input  ctrlStrobe_t                strobe,
  output hitFlags_t                  hits,
  output logic                       dstExp,
  output logic                       dstDef,
  output logic                       undefCfg
);
  localparam int N_VGA  = 2;
  localparam int N_MONO = 3;
  localparam logic [N_VGA-1:0][9:0]  VGA_LO  = {10'h3C0, 10'h3B0};
  localparam logic [N_VGA-1:0][9:0]  VGA_HI  = {10'h3DF, 10'h3BB};
  localparam logic [N_MONO-1:0][9:0] MONO_LO = {10'h3BF, 10'h3B8, 10'h3B4};
  localparam logic [N_MONO-1:0][9:0] MONO_HI = {10'h3BF, 10'h3BA, 10'h3B5};
  localparam logic [ADDR_W-1:0] VGA_MEM_LO  = ADDR_W'(32'h000A_0000);
  localparam logic [ADDR_W-1:0] VGA_MEM_HI  = ADDR_W'(32'h000B_FFFF);
  localparam logic [ADDR_W-1:0] MONO_MEM_LO = ADDR_W'(32'h000B_0000);
  localparam logic [ADDR_W-1:0] MONO_MEM_HI = ADDR_W'(32'h000B_7FFF);

  logic [9:0]                       lo10;
  logic [IO_W-IO_GRAN-1:0]          ioSel;
  logic [ADDR_W-MEM_GRAN-1:0]       memSel;
  logic [N_VGA-1:0]                 vgaHit;
  logic [N_MONO-1:0]                monoHit;

  assign lo10   = reqAddr[9:0];
  assign ioSel  = reqAddr[IO_W-1:IO_GRAN];
  assign memSel = reqAddr[ADDR_W-1:MEM_GRAN];

  for (genvar gi = 0; gi < N_VGA; gi++) begin : g_vga
    assign vgaHit[gi] = (lo10 >= VGA_LO[gi]) && (lo10 <= VGA_HI[gi]);
  end
  for (genvar gm = 0; gm < N_MONO; gm++) begin : g_mono
    assign monoHit[gm] = (lo10 >= MONO_LO[gm]) && (lo10 <= MONO_HI[gm]);
  end

  always_comb begin
    hits.vgaIo    = |vgaHit;
    hits.monoIo   = |monoHit;
    hits.portWin  = (lo10[9:2] == 8'hEF);
    hits.ioWin    = (ioSel >= ioBase) && (ioSel <= ioLimit);
    hits.ioHighNz = |lo10[9:8];
    hits.vgaMem   = (reqAddr >= VGA_MEM_LO) && (reqAddr <= VGA_MEM_HI);
    hits.monoMem  = (reqAddr >= MONO_MEM_LO) && (reqAddr <= MONO_MEM_HI);
    hits.memWin   = (memSel >= memBase) && (memSel <= memLimit);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dstExp   <= 1'b0;
      dstDef   <= 1'b0;
      undefCfg <= 1'b0;
    end else begin
      dstExp   <= strobe.load & strobe.toExp;
      dstDef   <= strobe.load & ~strobe.toExp;
      undefCfg <= strobe.load & strobe.undef;
    end
  end
endmodule

// File: rtl/lgr_ctrl.sv
`timescale 1ns/1ps
module lgr_ctrl
  import lgr_pkg::*;
(
  input  logic        reqValid,
  input  logic        reqIsIo,
  input  logic        vgaEn,
  input  logic        mdaEn,
  input  logic        isaEn,
  input  hitFlags_t   hits,
  output ctrlStrobe_t strobe
);
  logic monoOn;
  logic ioFallback;

  assign monoOn     = vgaEn && mdaEn;
  assign ioFallback = hits.ioWin && !(isaEn && hits.ioHighNz);

  always_comb begin
    strobe.load  = reqValid;
    strobe.undef = !vgaEn && mdaEn;
    if (reqIsIo) begin
      if ((monoOn && hits.monoIo) || (vgaEn && hits.portWin))
        strobe.toExp = 1'b0;
      else if (vgaEn && hits.vgaIo)
        strobe.toExp = 1'b1;
      else
        strobe.toExp = ioFallback;
    end else begin
      if (monoOn && hits.monoMem)
        strobe.toExp = 1'b0;
      else if (vgaEn && hits.vgaMem)
        strobe.toExp = 1'b1;
      else
        strobe.toExp = hits.memWin;
    end
  end
endmodule

// File: rtl/legacy_gfx_router.sv
`timescale 1ns/1ps
module legacy_gfx_router
  import lgr_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int IO_W     = 16,
  parameter int IO_GRAN  = 12,
  parameter int MEM_GRAN = 20,
  localparam int IO_SEL_W  = IO_W - IO_GRAN,
  localparam int MEM_SEL_W = ADDR_W - MEM_GRAN
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reqValid,
  input  logic                 reqIsIo,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic                 vgaEn,
  input  logic                 mdaEn,
  input  logic                 isaEn,
  input  logic [IO_SEL_W-1:0]  ioBase,
  input  logic [IO_SEL_W-1:0]  ioLimit,
  input  logic [MEM_SEL_W-1:0] memBase,
  input  logic [MEM_SEL_W-1:0] memLimit,
  output logic                 dstExp,
  output logic                 dstDef,
  output logic                 undefCfg
);
  hitFlags_t   hits;
  ctrlStrobe_t strobe;

  lgr_ctrl u_ctrl (
    .reqValid (reqValid),
    .reqIsIo  (reqIsIo),
    .vgaEn    (vgaEn),
    .mdaEn    (mdaEn),
    .isaEn    (isaEn),
    .hits     (hits),
    .strobe   (strobe)
  );

  lgr_datapath #(
    .ADDR_W(ADDR_W), .IO_W(IO_W), .IO_GRAN(IO_GRAN), .MEM_GRAN(MEM_GRAN)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .reqAddr  (reqAddr),
    .ioBase   (ioBase),
    .ioLimit  (ioLimit),
    .memBase  (memBase),
    .memLimit (memLimit),
    .strobe   (strobe),
    .hits     (hits),
    .dstExp   (dstExp),
    .dstDef   (dstDef),
    .undefCfg (undefCfg)
  );
endmodule

// File: rtl/legacy_gfx_router_chk.sv
`timescale 1ns/1ps
module legacy_gfx_router_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reqValid,
  input logic              reqIsIo,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              vgaEn,
  input logic              mdaEn,
  input logic              dstExp,
  input logic              dstDef,
  input logic              undefCfg
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !reqValid |=> (!dstExp && !dstDef && !undefCfg));

  p_one_dest_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |=> ($countones({dstExp, dstDef}) == 1));

  p_vga_mem_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && !reqIsIo && vgaEn && !mdaEn &&
     reqAddr >= ADDR_W'(32'h000A_0000) && reqAddr <= ADDR_W'(32'h000B_FFFF))
    |=> dstExp);

  p_port_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqIsIo && vgaEn && reqAddr[9:2] == 8'hEF) |=> dstDef);

  p_mono_mem_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && !reqIsIo && vgaEn && mdaEn &&
     reqAddr >= ADDR_W'(32'h000B_0000) && reqAddr <= ADDR_W'(32'h000B_7FFF))
    |=> dstDef);

  p_undef_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |=> (undefCfg == $past(!vgaEn && mdaEn)));
endmodule

bind legacy_gfx_router legacy_gfx_router_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reqValid (reqValid),
  .reqIsIo  (reqIsIo),
  .reqAddr  (reqAddr),
  .vgaEn    (vgaEn),
  .mdaEn    (mdaEn),
  .dstExp   (dstExp),
  .dstDef   (dstDef),
  .undefCfg (undefCfg)
);

// File: tb/legacy_gfx_router_bench.sv
`timescale 1ns/1ps
module legacy_gfx_router_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqIsIo = 1'b0;
  logic [31:0] reqAddr = '0;
  logic        vgaEn = 1'b0, mdaEn = 1'b0, isaEn = 1'b0;
  logic [3:0]  ioBase = '0, ioLimit = '0;
  logic [11:0] memBase = '0, memLimit = '0;
  logic        dstExp, dstDef, undefCfg;

  int nTests = 0;
  int nFail  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  legacy_gfx_router u_legacy_gfx_router (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqIsIo(reqIsIo),
    .reqAddr(reqAddr), .vgaEn(vgaEn), .mdaEn(mdaEn), .isaEn(isaEn),
    .ioBase(ioBase), .ioLimit(ioLimit), .memBase(memBase), .memLimit(memLimit),
    .dstExp(dstExp), .dstDef(dstDef), .undefCfg(undefCfg)
  );

  // Expected routing: 1 = expansion port
  function automatic logic refExp(logic io, logic [31:0] a, logic vga, logic mda,
                                  logic isa, logic [3:0] ib, logic [3:0] il,
                                  logic [11:0] mb, logic [11:0] ml);
    logic [9:0] p;
    p = a[9:0];
    if (io) begin
      if (vga && mda && (p == 10'h3B4 || p == 10'h3B5 || p == 10'h3B8 ||
                         p == 10'h3B9 || p == 10'h3BA || p == 10'h3BF)) return 1'b0;
      if (vga && p >= 10'h3BC && p <= 10'h3BF) return 1'b0;
      if (vga && ((p >= 10'h3B0 && p <= 10'h3BB) || (p >= 10'h3C0 && p <= 10'h3DF)))
        return 1'b1;
      return (a[15:12] >= ib) && (a[15:12] <= il) && !(isa && p[9:8] != 2'b00);
    end
    if (vga && mda && a >= 32'hB0000 && a <= 32'hB7FFF) return 1'b0;
    if (vga && a >= 32'hA0000 && a <= 32'hBFFFF) return 1'b1;
    return (a[31:20] >= mb) && (a[31:20] <= ml);
  endfunction

  task automatic check(string req, logic eE, logic eD, logic eU);
    nTests++;
    if ({dstExp, dstDef, undefCfg} !== {eE, eD, eU}) begin
      nFail++;
      $display("FAIL %s: got exp/def/undef=%b%b%b expected %b%b%b",
               req, dstExp, dstDef, undefCfg, eE, eD, eU);
    end
  endtask

  // Drive at a falling edge, check at the next falling edge
  task automatic req(string tag, logic io, logic [31:0] a, logic vga, logic mda,
                     logic isa, logic [3:0] ib, logic [3:0] il,
                     logic [11:0] mb, logic [11:0] ml);
    logic e;
    reqValid = 1'b1; reqIsIo = io; reqAddr = a;
    vgaEn = vga; mdaEn = mda; isaEn = isa;
    ioBase = ib; ioLimit = il; memBase = mb; memLimit = ml;
    e = refExp(io, a, vga, mda, isa, ib, il, mb, ml);
    @(negedge clk);
    check(tag, e, !e, !vga && mda);
  endtask

  task automatic idle(string tag);
    reqValid = 1'b0;
    reqAddr = 32'h000A_0000; vgaEn = 1'b0; mdaEn = 1'b1;
    @(negedge clk);
    check(tag, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 reset", 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;

    // R3: legacy memory window overrides memory window registers
    req("R3 low edge",   0, 32'h000A_0000, 1, 0, 0, 4'h0, 4'h0, 12'h005, 12'h006);
    req("R3 high edge",  0, 32'h000B_FFFF, 1, 0, 0, 4'h0, 4'h0, 12'h005, 12'h006);
    req("R3 above",      0, 32'h000C_0000, 1, 0, 0, 4'h0, 4'h0, 12'h005, 12'h006);
    req("R3 below",      0, 32'h0009_FFFF, 1, 0, 0, 4'h0, 4'h0, 12'h005, 12'h006);
    // R4: legacy I/O ports, aliases, independent of window and ISA
    req("R4 3C0",        1, 32'h0000_03C0, 1, 0, 1, 4'hF, 4'hF, 12'h0, 12'h0);
    req("R4 alias",      1, 32'h0000_FBDF, 1, 0, 1, 4'hF, 4'hF, 12'h0, 12'h0);
    req("R4 3BB",        1, 32'h0000_07BB, 1, 0, 1, 4'hF, 4'hF, 12'h0, 12'h0);
    req("R4 3E0 out",    1, 32'h0000_03E0, 1, 0, 0, 4'hF, 4'hF, 12'h0, 12'h0);
    // R5: 0x3BC..0x3BF to default even inside the I/O window
    req("R5 3BC",        1, 32'h0000_03BC, 1, 0, 0, 4'h0, 4'hF, 12'h0, 12'h0);
    req("R5 alias 3BE",  1, 32'h0000_73BE, 1, 0, 0, 4'h0, 4'hF, 12'h0, 12'h0);
    // R6: mono carve-out
    req("R6 io 3B4",     1, 32'h0000_03B4, 1, 1, 0, 4'h0, 4'hF, 12'h0, 12'h0);
    req("R6 io 3BA",     1, 32'h0000_03BA, 1, 1, 0, 4'hF, 4'hF, 12'h0, 12'h0);
    req("R6 io 3BB",     1, 32'h0000_03BB, 1, 1, 0, 4'hF, 4'hF, 12'h0, 12'h0);
    req("R6 io mda off", 1, 32'h0000_03B4, 1, 0, 0, 4'hF, 4'hF, 12'h0, 12'h0);
    req("R6 mem B0000",  0, 32'h000B_0000, 1, 1, 0, 4'h0, 4'h0, 12'h0, 12'h0);
    req("R6 mem B7FFF",  0, 32'h000B_7FFF, 1, 1, 0, 4'h0, 4'h0, 12'h0, 12'h0);
    req("R6 mem B8000",  0, 32'h000B_8000, 1, 1, 0, 4'h0, 4'h0, 12'h1, 12'h1);
    // R7: I/O window and ISA exclusion
    req("R7 in window",  1, 32'h0000_03C0, 0, 0, 0, 4'h0, 4'h0, 12'h0, 12'h0);
    req("R7 isa cut",    1, 32'h0000_03C0, 0, 0, 1, 4'h0, 4'h0, 12'h0, 12'h0);
    req("R7 isa pass",   1, 32'h0000_20C0, 0, 0, 1, 4'h2, 4'h2, 12'h0, 12'h0);
    req("R7 limit top",  1, 32'h0000_2FFF, 0, 0, 0, 4'h2, 4'h2, 12'h0, 12'h0);
    req("R7 above lim",  1, 32'h0000_3000, 0, 0, 0, 4'h2, 4'h2, 12'h0, 12'h0);
    req("R7 3BC no vga", 1, 32'h0000_03BC, 0, 0, 0, 4'h0, 4'h0, 12'h0, 12'h0);
    req("R7 high bits",  1, 32'h0001_20C0, 0, 0, 0, 4'h2, 4'h2, 12'h0, 12'h0);
    // R8: memory window
    req("R8 vga mem off",0, 32'h000A_0000, 0, 0, 0, 4'h0, 4'h0, 12'h000, 12'h000);
    req("R8 below base", 0, 32'h000A_0000, 0, 0, 0, 4'h0, 4'h0, 12'h001, 12'h003);
    req("R8 in window",  0, 32'h0030_0000, 0, 0, 0, 4'h0, 4'h0, 12'h001, 12'h003);
    req("R8 above lim",  0, 32'h0040_0000, 0, 0, 0, 4'h0, 4'h0, 12'h001, 12'h003);
    // R9: unsupported combination
    req("R9 undef io",   1, 32'h0000_03B4, 0, 1, 0, 4'h0, 4'h0, 12'h0, 12'h0);
    req("R9 undef mem",  0, 32'h000B_0000, 0, 1, 0, 4'h0, 4'h0, 12'h1, 12'h1);
    // R1: idle cycle clears outputs
    idle("R1 idle");

    for (int i = 0; i < 600; i++) begin
      logic        io;
      logic [31:0] a;
      logic [3:0]  ib, il;
      logic [11:0] mb, ml;
      io = 1'($urandom);
      a  = $urandom;
      if ($urandom % 4 != 0) begin
        if (io) a[9:0] = 10'h3A8 + 10'($urandom % 64);
        else    a = 32'h0009_8000 + ($urandom % 32'h3_0000);
      end
      ib = 4'($urandom); il = 4'($urandom);
      mb = 12'($urandom % 8); ml = 12'($urandom % 8);
      req("R2 random", io, a, 1'($urandom), 1'($urandom), 1'($urandom), ib, il, mb, ml);
      if ($urandom % 16 == 0) idle("R1 random idle");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule